// File: doc/BRIEF.md
# Byte-Addressed Wide-Word Scratch Memory

This block is a read-write scratch store organised as 256-bit words, each holding 32 bytes, but addressed one byte at a time through a 32-bit byte address. A requester issues one of three commands on a valid/ready port: fetch the 32 bytes starting at any byte address, overwrite the 32 bytes starting at any byte address, or overwrite a single byte. Within a word the byte with the lowest address is the most significant. After reset every location reads as zero.

The backing array allows one word access per cycle and writes whole words only. A 32-byte command whose start is a multiple of 32 maps onto a single word and finishes in the cycle it is accepted. A start that is not a multiple of 32 spans that word and the next one. The block then reads both words and shifts the bytes into place. For a store it reads both words, merges the new bytes in, and writes both words back. A single-byte store reads its one word, replaces the byte and writes it back. Commands that fall outside the array or carry the reserved opcode are refused with a one-cycle error pulse and change nothing.

Top module: `bwm_top`

## Requirements
- R1: After reset, every byte reads as zero, and the outputs hold `cmd_ready`=1, `rsp_valid`=0 and `cmd_err`=0.
- R2: A load (`cmd_op`=2'b00) at byte address k returns bytes k..k+31 on `rsp_data`. Byte k is placed in bits [255:248] and byte k+31 in bits [7:0].
- R3: A 32-byte store (`cmd_op`=2'b01) at byte address k writes `cmd_wdata`[255:248] to byte k, down to `cmd_wdata`[7:0] at byte k+31. All other bytes keep their contents.
- R4: A byte store (`cmd_op`=2'b10) writes `cmd_wdata`[7:0] to byte k only. All other bytes keep their contents.
- R5: When k[4:0]=0, an in-range load raises `rsp_valid` for exactly one cycle, in the cycle after acceptance. Both aligned loads and aligned stores keep `cmd_ready` high in that cycle.
- R6: When k[4:0]≠0, an in-range load drops `cmd_ready` for one cycle after acceptance. `rsp_valid` is then high for exactly one cycle, two cycles after acceptance, and `cmd_ready` returns high in that same cycle.
- R7: When k[4:0]≠0, an in-range 32-byte store holds `cmd_ready` low for the three cycles after acceptance, and it is high again in the fourth.
- R8: An in-range byte store holds `cmd_ready` low for one cycle after acceptance.
- R9: A 32-byte command is out of range when floor((k+31)/32) ≥ DEPTH, where k+31 is computed without wrap. A byte store is out of range when floor(k/32) ≥ DEPTH. Either case raises `cmd_err` for one cycle after acceptance, gives no response, leaves memory unchanged and keeps `cmd_ready` high.
- R10: The reserved opcode 2'b11 is refused in the same way as in R9, whatever the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block can accept a command this cycle |
| cmd_op | input | 2 | 00 load 32 bytes, 01 store 32 bytes, 10 store byte, 11 reserved |
| cmd_addr | input | 32 | Byte address of the first byte |
| cmd_wdata | input | 256 | Store data; the byte store uses bits [7:0] |
| rsp_valid | output | 1 | Load data valid, one-cycle pulse |
| rsp_data | output | 256 | Load data, first byte in the top bits |
| cmd_err | output | 1 | Command refused, one-cycle pulse |

## Verification
The timing properties assume the requester never asserts `cmd_valid` while the internal reset is still held. They also assume the requester judges each command only by the cycles that follow its acceptance, so they never follow a command across a later one. The stimulus meets both conditions. It leaves a gap after reset. It issues each command only when `cmd_ready` is high, then lets the block go idle before the next command. Random addresses mostly stay inside the array. A small share, together with directed cases at the last word, at the top of the 32-bit space and with the reserved opcode, is chosen to exercise refusal.

// File: rtl/bwm_pkg.sv
package bwm_pkg;
  localparam int unsigned WORD_BYTES = 32;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned WORD_W     = WORD_BYTES * BYTE_W;
  localparam int unsigned LANE_W     = $clog2(WORD_BYTES);

  typedef enum logic [1:0] {
    OP_LD32 = 2'b00,
    OP_ST32 = 2'b01,
    OP_ST8  = 2'b10,
    OP_RSVD = 2'b11
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LD_HI,
    S_ST_RDHI,
    S_ST_WRLO,
    S_ST_WRHI,
    S_B_WR
  } st_e;
endpackage

// File: rtl/bwm_addr_dec.sv
module bwm_addr_dec
  import bwm_pkg::*;
#(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = $clog2(DEPTH)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        op,
  output logic [IDX_W-1:0]  lo_idx,
  output logic [LANE_W-1:0] lane,
  output logic              unaligned,
  output logic              refuse
);
  localparam int unsigned WIDX_W = ADDR_W + 1 - LANE_W;
  localparam logic [WIDX_W-1:0] LIMIT = WIDX_W'(DEPTH);

  logic [ADDR_W:0]   last_byte;
  logic [WIDX_W-1:0] last_word;

  always_comb begin
    last_byte = {1'b0, addr} + ((op == OP_ST8) ? '0 : (ADDR_W+1)'(WORD_BYTES - 1));
    last_word = last_byte[ADDR_W:LANE_W];
    lo_idx    = addr[LANE_W +: IDX_W];
    lane      = addr[LANE_W-1:0];
    unaligned = (lane != '0);
    refuse    = (op == OP_RSVD) || (last_word >= LIMIT);
  end
endmodule

// File: rtl/bwm_lane_merge.sv
module bwm_lane_merge
  import bwm_pkg::*;
(
  input  logic [WORD_W-1:0] lo_word,
  input  logic [WORD_W-1:0] hi_word,
  input  logic [LANE_W-1:0] lane,
  input  logic [WORD_W-1:0] new_data,
  input  logic [BYTE_W-1:0] new_byte,
  output logic [WORD_W-1:0] ld_word,
  output logic [WORD_W-1:0] st_lo,
  output logic [WORD_W-1:0] st_hi,
  output logic [WORD_W-1:0] b_word
);
  logic [2*WORD_W-1:0] pair, shifted, mask, placed, merged;
  logic [WORD_W-1:0]   bmask, bplaced;
  logic [LANE_W+2:0]   bits;

  always_comb begin
    bits    = {lane, 3'b000};
    pair    = {lo_word, hi_word};
    shifted = pair << bits;
    ld_word = shifted[2*WORD_W-1:WORD_W];
    mask    = {{WORD_W{1'b1}}, {WORD_W{1'b0}}} >> bits;
    placed  = {new_data, {WORD_W{1'b0}}} >> bits;
    merged  = (pair & ~mask) | placed;
    st_lo   = merged[2*WORD_W-1:WORD_W];
    st_hi   = merged[WORD_W-1:0];
    bmask   = {{BYTE_W{1'b1}}, {(WORD_W-BYTE_W){1'b0}}} >> bits;
    bplaced = {new_byte, {(WORD_W-BYTE_W){1'b0}}} >> bits;
    b_word  = (lo_word & ~bmask) | bplaced;
  end
endmodule

// File: rtl/bwm_word_store.sv
module bwm_word_store
  import bwm_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_word,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_word
);
  logic [WORD_W-1:0] mem_q [DEPTH];

  generate
    if (DEPTH == (1 << IDX_W)) begin : g_full
      assign rd_word = mem_q[rd_idx];
    end else begin : g_part
      assign rd_word = (32'(rd_idx) < DEPTH) ? mem_q[rd_idx] : '0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (wr_en) begin
      mem_q[wr_idx] <= wr_word;
    end
  end
endmodule

// File: rtl/bwm_top.sv
module bwm_top
  import bwm_pkg::*;
#(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [255:0]      cmd_wdata,
  output logic              rsp_valid,
  output logic [255:0]      rsp_data,
  output logic              cmd_err
);
  localparam int unsigned IDX_W = $clog2(DEPTH);

  logic rst_meta, rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_n_s  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_n_s  <= rst_meta;
    end
  end

  st_e               st_q, st_d;
  logic [IDX_W-1:0]  lo_q, lo_d, hi_idx;
  logic [LANE_W-1:0] ln_q, ln_d;
  logic [WORD_W-1:0] wd_q, wd_d, blo_q, blo_d, bhi_q, bhi_d, rspd_q, rspd_d;
  logic              rspv_q, rspv_d, err_q, err_d;

  logic [IDX_W-1:0]  dec_lo;
  logic [LANE_W-1:0] dec_lane;
  logic              dec_unal, dec_refuse;
  logic [IDX_W-1:0]  rd_idx, wr_idx;
  logic [WORD_W-1:0] rd_word, wr_word, hi_in, ld_word, st_lo, st_hi, b_word;
  logic              wr_en;

  bwm_addr_dec #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) dec_i (
    .addr(cmd_addr), .op(cmd_op), .lo_idx(dec_lo), .lane(dec_lane),
    .unaligned(dec_unal), .refuse(dec_refuse)
  );

  bwm_lane_merge merge_i (
    .lo_word(blo_q), .hi_word(hi_in), .lane(ln_q), .new_data(wd_q),
    .new_byte(wd_q[BYTE_W-1:0]), .ld_word(ld_word), .st_lo(st_lo),
    .st_hi(st_hi), .b_word(b_word)
  );

  bwm_word_store #(.DEPTH(DEPTH), .IDX_W(IDX_W)) store_i (
    .clk(clk), .rst_n(rst_n_s), .rd_idx(rd_idx), .rd_word(rd_word),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_word(wr_word)
  );

  assign hi_idx    = lo_q + IDX_W'(1);
  assign cmd_ready = (st_q == S_IDLE);
  assign rsp_valid = rspv_q;
  assign rsp_data  = rspd_q;
  assign cmd_err   = err_q;

  always_comb begin
    st_d    = st_q;
    lo_d    = lo_q;
    ln_d    = ln_q;
    wd_d    = wd_q;
    blo_d   = blo_q;
    bhi_d   = bhi_q;
    rspd_d  = rspd_q;
    rspv_d  = 1'b0;
    err_d   = 1'b0;
    rd_idx  = hi_idx;
    hi_in   = bhi_q;
    wr_en   = 1'b0;
    wr_idx  = lo_q;
    wr_word = st_lo;
    unique case (st_q)
      S_IDLE: begin
        rd_idx = dec_lo;
        if (cmd_valid) begin
          lo_d = dec_lo;
          ln_d = dec_lane;
          wd_d = cmd_wdata;
          if (dec_refuse) begin
            err_d = 1'b1;
          end else begin
            unique case (op_e'(cmd_op))
              OP_LD32: begin
                if (!dec_unal) begin
                  rspv_d = 1'b1;
                  rspd_d = rd_word;
                end else begin
                  blo_d = rd_word;
                  st_d  = S_LD_HI;
                end
              end
              OP_ST32: begin
                if (!dec_unal) begin
                  wr_en   = 1'b1;
                  wr_idx  = dec_lo;
                  wr_word = cmd_wdata;
                end else begin
                  blo_d = rd_word;
                  st_d  = S_ST_RDHI;
                end
              end
              OP_ST8: begin
                blo_d = rd_word;
                st_d  = S_B_WR;
              end
              default: ;
            endcase
          end
        end
      end
      S_LD_HI: begin
        hi_in  = rd_word;
        rspv_d = 1'b1;
        rspd_d = ld_word;
        st_d   = S_IDLE;
      end
      S_ST_RDHI: begin
        bhi_d = rd_word;
        st_d  = S_ST_WRLO;
      end
      S_ST_WRLO: begin
        wr_en   = 1'b1;
        wr_idx  = lo_q;
        wr_word = st_lo;
        st_d    = S_ST_WRHI;
      end
      S_ST_WRHI: begin
        wr_en   = 1'b1;
        wr_idx  = hi_idx;
        wr_word = st_hi;
        st_d    = S_IDLE;
      end
      S_B_WR: begin
        wr_en   = 1'b1;
        wr_idx  = lo_q;
        wr_word = b_word;
        st_d    = S_IDLE;
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      st_q   <= S_IDLE;
      lo_q   <= '0;
      ln_q   <= '0;
      wd_q   <= '0;
      blo_q  <= '0;
      bhi_q  <= '0;
      rspd_q <= '0;
      rspv_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      lo_q   <= lo_d;
      ln_q   <= ln_d;
      wd_q   <= wd_d;
      blo_q  <= blo_d;
      bhi_q  <= bhi_d;
      rspd_q <= rspd_d;
      rspv_q <= rspv_d;
      err_q  <= err_d;
    end
  end
endmodule

// File: rtl/bwm_top_chk.sv
module bwm_top_chk #(
  parameter int unsigned DEPTH = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic        cmd_ready,
  input logic [1:0]  cmd_op,
  input logic [31:0] cmd_addr,
  input logic        rsp_valid,
  input logic        cmd_err
);
  logic [32:0] last_b;
  logic        acc, in32, in8, unal, ok_ld, ok_st, ok_b, refused;
  logic [2:0]  busy_cnt;

  assign last_b  = {1'b0, cmd_addr} + 33'd31;
  assign acc     = cmd_valid && cmd_ready;
  assign in32    = (last_b[32:5] < 28'(DEPTH));
  assign in8     = (cmd_addr[31:5] < 27'(DEPTH));
  assign unal    = (cmd_addr[4:0] != 5'd0);
  assign ok_ld   = acc && (cmd_op == 2'b00) && in32;
  assign ok_st   = acc && (cmd_op == 2'b01) && in32;
  assign ok_b    = acc && (cmd_op == 2'b10) && in8;
  assign refused = acc && !(ok_ld || ok_st || ok_b);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               busy_cnt <= '0;
    else if (cmd_ready)       busy_cnt <= '0;
    else if (busy_cnt != '1)  busy_cnt <= busy_cnt + 3'd1;
  end

  p_aligned_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ok_ld && !unal |=> rsp_valid && cmd_ready);
  p_aligned_store_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ok_st && !unal |=> cmd_ready && !rsp_valid);
  p_unal_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ok_ld && unal |=> (!cmd_ready && !rsp_valid) ##1 (rsp_valid && cmd_ready));
  p_unal_store_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ok_st && unal |=> !cmd_ready ##1 !cmd_ready ##1 !cmd_ready ##1 cmd_ready);
  p_busy_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_cnt <= 3'd3);
  p_byte_store_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ok_b |=> !cmd_ready ##1 cmd_ready);
  p_refuse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    refused |=> cmd_err && !rsp_valid && cmd_ready);
  p_err_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> $past(refused));
endmodule

bind bwm_top bwm_top_chk #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n_s), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .cmd_addr(cmd_addr), .rsp_valid(rsp_valid), .cmd_err(cmd_err)
);

// File: tb/bwm_top_tb_top.sv
module bwm_top_tb_top;
  localparam int DEPTH = 16;
  localparam int NBYTES = DEPTH * 32;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         cmd_valid;
  logic         cmd_ready;
  logic [1:0]   cmd_op;
  logic [31:0]  cmd_addr;
  logic [255:0] cmd_wdata;
  logic         rsp_valid;
  logic [255:0] rsp_data;
  logic         cmd_err;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  logic [7:0] model [NBYTES];

  always #10 clk = ~clk;

  bwm_top #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .cmd_err(cmd_err)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: actual=%0d expected<150000 cycles", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input logic ok, input string tag,
                       input logic [255:0] act, input logic [255:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [255:0] model_load(input int k);
    logic [255:0] r;
    for (int i = 0; i < 32; i++) r[255-8*i -: 8] = model[k+i];
    return r;
  endfunction

  task automatic run_cmd(input logic [1:0] op, input logic [31:0] a,
                         input logic [255:0] d, input string dtag);
    longint last;
    logic   refuse, unal;
    int     exp_rdy, exp_rsp, rdy_at, rsp_at, rsp_n, err_n;
    string  ttag;
    logic [255:0] got;
    last   = longint'(a) + ((op == 2'b10) ? 0 : 31);
    refuse = (op == 2'b11) || ((last >> 5) >= DEPTH);
    unal   = (a[4:0] != 5'd0);
    exp_rsp = (!refuse && op == 2'b00) ? 1 : 0;
    if (refuse) begin
      exp_rdy = 1; ttag = (op == 2'b11) ? "R10" : "R9";
    end else if (op == 2'b00) begin
      exp_rdy = unal ? 2 : 1; ttag = unal ? "R6" : "R5";
    end else if (op == 2'b01) begin
      exp_rdy = unal ? 4 : 1; ttag = unal ? "R7" : "R5";
    end else begin
      exp_rdy = 2; ttag = "R8";
    end
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_wdata = d;
    @(negedge clk);
    cmd_valid = 1'b0;
    rdy_at = 0; rsp_at = 0; rsp_n = 0; err_n = 0; got = '0;
    for (int i = 1; i <= 5; i++) begin
      if (cmd_ready && rdy_at == 0) rdy_at = i;
      if (rsp_valid) begin rsp_n++; rsp_at = i; got = rsp_data; end
      if (cmd_err) err_n++;
      if (i < 5) @(negedge clk);
    end
    check(rdy_at == exp_rdy, {ttag, " ready return"}, 256'(rdy_at), 256'(exp_rdy));
    check(rsp_n == exp_rsp, {ttag, " response count"}, 256'(rsp_n), 256'(exp_rsp));
    check(err_n == (refuse ? 1 : 0), {ttag, " error pulse"}, 256'(err_n), 256'(refuse));
    if (exp_rsp == 1) begin
      check(rsp_at == exp_rdy, {ttag, " response cycle"}, 256'(rsp_at), 256'(exp_rdy));
      check(got == model_load(int'(a)), {dtag, " load data"}, got, model_load(int'(a)));
    end
    if (!refuse && op == 2'b01)
      for (int i = 0; i < 32; i++) model[int'(a)+i] = d[255-8*i -: 8];
    if (!refuse && op == 2'b10) model[int'(a)] = d[7:0];
  endtask

  function automatic logic [255:0] rnd256();
    logic [255:0] r;
    for (int i = 0; i < 8; i++) r[32*i +: 32] = $urandom;
    return r;
  endfunction

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < NBYTES; i++) model[i] = 8'h00;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 2'b00; cmd_addr = '0; cmd_wdata = '0;
    repeat (3) @(negedge clk);
    check(cmd_ready == 1'b1, "R1 reset ready", 256'(cmd_ready), 256'(1));
    check(rsp_valid == 1'b0, "R1 reset rsp_valid", 256'(rsp_valid), 256'(0));
    check(cmd_err == 1'b0, "R1 reset cmd_err", 256'(cmd_err), 256'(0));
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1: every word and some straddling reads are zero
    for (int w = 0; w < DEPTH; w++) run_cmd(2'b00, 32'(w*32), '0, "R1");
    run_cmd(2'b00, 32'd17, '0, "R1");
    run_cmd(2'b00, 32'(NBYTES-32), '0, "R1");

    // R3: stores at various lane offsets, checked via neighbours
    run_cmd(2'b01, 32'd5, {8{32'hA1B2C3D4}}, "R3");
    run_cmd(2'b00, 32'd0, '0, "R3");
    run_cmd(2'b00, 32'd32, '0, "R3");
    run_cmd(2'b01, 32'd95, rnd256(), "R3");
    run_cmd(2'b00, 32'd64, '0, "R3");
    run_cmd(2'b00, 32'd96, '0, "R3");
    run_cmd(2'b01, 32'(NBYTES-32), rnd256(), "R3");
    run_cmd(2'b00, 32'(NBYTES-33), '0, "R3");

    // R4: byte stores at word edges
    run_cmd(2'b10, 32'd0, 256'h5A, "R4");
    run_cmd(2'b10, 32'd31, 256'hC3, "R4");
    run_cmd(2'b10, 32'd32, 256'h7E, "R4");
    run_cmd(2'b10, 32'(NBYTES-1), 256'h99, "R4");
    run_cmd(2'b00, 32'd0, '0, "R4");
    run_cmd(2'b00, 32'd16, '0, "R4");
    run_cmd(2'b00, 32'(NBYTES-32), '0, "R4");

    // R9: out of range, memory unchanged afterwards
    run_cmd(2'b01, 32'(NBYTES-31), rnd256(), "R9");
    run_cmd(2'b00, 32'(NBYTES-1), '0, "R9");
    run_cmd(2'b01, 32'hFFFF_FFF0, rnd256(), "R9");
    run_cmd(2'b10, 32'(NBYTES), 256'h11, "R9");
    run_cmd(2'b00, 32'(NBYTES-32), '0, "R9");

    // R10: reserved opcode changes nothing
    run_cmd(2'b11, 32'd0, rnd256(), "R10");
    run_cmd(2'b00, 32'd0, '0, "R10");

    // R2: random mix
    for (int n = 0; n < 600; n++) begin
      int sel;
      logic [31:0] a;
      sel = int'($urandom % 10);
      a = 32'($urandom % (NBYTES - 31));
      if (sel < 4)       run_cmd(2'b00, a, '0, "R2");
      else if (sel < 7)  run_cmd(2'b01, a, rnd256(), "R3");
      else if (sel < 9)  run_cmd(2'b10, 32'($urandom % NBYTES), rnd256(), "R4");
      else               run_cmd(2'($urandom % 4), 32'(NBYTES - 31 + int'($urandom % 64)), rnd256(), "R9");
    end
    for (int w = 0; w < DEPTH; w++) run_cmd(2'b00, 32'(w*32 + 3), '0, "R2");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule